// File: doc/BRIEF.md
# Multiprocessor UART Receiver with Wake-up Filter

This block receives asynchronous serial characters and places them in a one-entry receive data register. Status flags report data full, framing error, overrun and a received address mark, and two interrupt lines signal data and errors. Each character carries one extra mark bit after the eight data bits, so a link shared by several receivers can tell address characters from data characters.

When the multiprocessor mode is selected, software can arm a wake-up filter. While the filter is armed, every character whose mark bit is 0 is thrown away without a trace. It does not load the data register, it does not touch any flag and it raises no interrupt. The first character whose mark bit is 1 sets the mark flag, disarms the filter in hardware and is then received in the normal way. Software reads the address, decides whether the following data belongs to it, and either stays awake or arms the filter again.

The line is oversampled with an external baud tick, 16 ticks per bit. Software clears the error and mark flags with single-cycle clear pulses. Reading the data register clears the data-full flag.

Top module: `mpwake_uart_rx`

## Requirements
- R1: A character is received only while `rx_en` is 1 and a low level on `rx_line` is still low at the middle of the start bit (8 ticks after the first low tick). A low pulse shorter than that is discarded, and no character is received while `rx_en` is 0.
- R2: A character is a start bit (0), 8 data bits with the least significant bit first, one mark bit and one stop bit, each 16 ticks long. An accepted character with `data_full` at 0 loads `rx_data` and sets `data_full`.
- R3: An accepted character whose stop bit samples as 0 sets `frame_err`.
- R4: An accepted character that completes while `data_full` is 1 sets `overrun` and leaves `rx_data` unchanged.
- R5: A `rd_strobe` pulse clears `data_full`. `frame_err`, `overrun` and `mp_flag` stay set until their own clear pulses (`clr_fer`, `clr_ore`, `clr_mpbf`).
- R6: While `rx_en` is 0, `data_full`, `frame_err` and `overrun` keep their values.
- R7: The wake-up filter acts only while `mp_mode` is 1. With `mp_mode` at 0, characters are accepted normally even when `wake_armed` is 1, and `wake_armed` keeps its value.
- R8: While the filter is armed and `mp_mode` is 1, a character with mark bit 0 is discarded. `rx_data`, `data_full`, `frame_err` and `overrun` do not change, even when its stop bit is 0.
- R9: While the filter is armed and `mp_mode` is 1, `rx_irq` and `err_irq` are both 0.
- R10: While the filter is armed and `mp_mode` is 1, a character with mark bit 1 clears `wake_armed` and sets `mp_flag`. It is then accepted normally, including the framing and overrun checks.
- R11: When the filter is not in effect, `rx_irq` equals `rx_irq_en AND data_full`, and `err_irq` equals `rx_irq_en AND (frame_err OR overrun)`.
- R12: With `mp_mode` at 1, any accepted character with mark bit 1 sets `mp_flag`. With `mp_mode` at 0, `mp_flag` is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| rx_line | input | 1 | Serial input, idle high |
| rx_en | input | 1 | Receiver enable |
| mp_mode | input | 1 | Selects multiprocessor mode |
| wake_set | input | 1 | Pulse that arms the wake-up filter |
| wake_clr | input | 1 | Pulse that disarms the wake-up filter |
| rx_irq_en | input | 1 | Enables both interrupts |
| rd_strobe | input | 1 | Data register read, clears data_full |
| clr_fer | input | 1 | Clears frame_err |
| clr_ore | input | 1 | Clears overrun |
| clr_mpbf | input | 1 | Clears mp_flag |
| rx_data | output | 8 | Receive data register |
| data_full | output | 1 | Receive data valid |
| frame_err | output | 1 | Framing error flag |
| overrun | output | 1 | Overrun flag |
| mp_flag | output | 1 | Mark bit of 1 received |
| wake_armed | output | 1 | Wake-up filter armed |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Error interrupt |

## Verification
The vector table pairs each combination of mark bit, stop bit, `mp_mode` and filter state with one character. This separates a discarded character (data register and flags untouched) from an accepted one, and an address that releases the filter from one that merely sets the mark flag. The bad-stop vectors show that framing errors are suppressed while the filter is armed but reported on the waking address. The armed vector with `mp_mode` at 0 shows that the filter is ignored outside multiprocessor mode. Directed sequences cover overrun against a held register, flag retention with the receiver disabled, a start glitch shorter than half a bit, and interrupt masking while the filter is armed.

// File: rtl/mpwake_pkg.sv
package mpwake_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              flag;
    logic              stop_ok;
  } rx_frame_t;

  // start + data + mark + stop
  function automatic int frame_bits(input int dw);
    return dw + 3;
  endfunction

  // tick index within a bit at which the line is sampled
  function automatic int mid_tick(input int ovs);
    return ovs / 2 - 1;
  endfunction

  function automatic logic irq_rx(input logic en, input logic full, input logic armed);
    return en & full & ~armed;
  endfunction

  function automatic logic irq_err(input logic en, input logic fe, input logic oe, input logic armed);
    return en & (fe | oe) & ~armed;
  endfunction
endpackage

// File: rtl/mpw_bit_sampler.sv
module mpw_bit_sampler #(
  parameter int OVS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  baud_tick,
  input  logic                  rx_line,
  input  logic                  rx_en,
  output logic                  fr_valid,
  output mpwake_pkg::rx_frame_t fr
);
  import mpwake_pkg::*;

  localparam int CW    = $clog2(OVS);
  localparam int NBITS = frame_bits(DATA_W);
  localparam int IW    = $clog2(NBITS + 1);
  localparam logic [CW-1:0] MID  = CW'(mid_tick(OVS));
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic              busy;
  logic [CW-1:0]     tcnt;
  logic [IW-1:0]     bidx;
  logic [DATA_W-1:0] shreg;
  logic              flag_q;

  // named events for assertions
  logic start_seen, sample_now;
  assign start_seen = rx_en && !busy && baud_tick && !rx_line;
  assign sample_now = rx_en && busy && baud_tick && (tcnt == MID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      tcnt     <= '0;
      bidx     <= '0;
      shreg    <= '0;
      flag_q   <= 1'b0;
      fr_valid <= 1'b0;
      fr       <= '0;
    end else begin
      fr_valid <= 1'b0;
      if (!rx_en) begin
        busy <= 1'b0;
      end else if (!busy) begin
        if (start_seen) begin
          busy <= 1'b1;
          tcnt <= '0;
          bidx <= '0;
        end
      end else if (baud_tick) begin
        tcnt <= (tcnt == LAST) ? '0 : tcnt + 1'b1;
        if (tcnt == LAST) bidx <= bidx + 1'b1;
        if (sample_now) begin
          if (bidx == '0) begin
            if (rx_line) busy <= 1'b0;           // glitch, not a start bit
          end else if (bidx <= IW'(DATA_W)) begin
            shreg <= {rx_line, shreg[DATA_W-1:1]};
          end else if (bidx == IW'(DATA_W + 1)) begin
            flag_q <= rx_line;
          end else begin
            busy       <= 1'b0;
            fr_valid   <= 1'b1;
            fr.data    <= shreg;
            fr.flag    <= flag_q;
            fr.stop_ok <= rx_line;
          end
        end
      end
    end
  end

  // R1
  fr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid |=> !fr_valid);

  // R1
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !busy && !fr_valid);
endmodule

// File: rtl/mpw_rx_status.sv
module mpw_rx_status (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_en,
  input  logic                      mp_mode,
  input  logic                      wake_set,
  input  logic                      wake_clr,
  input  logic                      rd_strobe,
  input  logic                      clr_fer,
  input  logic                      clr_ore,
  input  logic                      clr_mpbf,
  input  logic                      fr_valid,
  input  mpwake_pkg::rx_frame_t     fr,
  output logic [mpwake_pkg::DATA_W-1:0] rx_data,
  output logic                      data_full,
  output logic                      frame_err,
  output logic                      overrun,
  output logic                      mp_flag,
  output logic                      wake_en,
  output logic                      wake_active
);
  // named events
  logic frame_in, frame_drop, frame_acc, wake_hit, load_ok, overrun_ev, fer_ev;

  assign wake_active = wake_en && mp_mode;
  assign frame_in    = fr_valid && rx_en;
  assign frame_drop  = frame_in && wake_active && !fr.flag;
  assign frame_acc   = frame_in && !frame_drop;
  assign wake_hit    = frame_in && wake_active && fr.flag;
  assign load_ok     = frame_acc && !data_full;
  assign overrun_ev  = frame_acc && data_full;
  assign fer_ev      = frame_acc && !fr.stop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      data_full <= 1'b0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
      mp_flag   <= 1'b0;
      wake_en   <= 1'b0;
    end else begin
      if (rd_strobe) data_full <= 1'b0;
      if (load_ok) begin
        data_full <= 1'b1;
        rx_data   <= fr.data;
      end
      if (clr_fer) frame_err <= 1'b0;
      if (fer_ev)  frame_err <= 1'b1;
      if (clr_ore)    overrun <= 1'b0;
      if (overrun_ev) overrun <= 1'b1;
      if (clr_mpbf) mp_flag <= 1'b0;
      if (frame_acc && mp_mode && fr.flag) mp_flag <= 1'b1;
      if (wake_set) wake_en <= 1'b1;
      if (wake_clr || wake_hit) wake_en <= 1'b0;
    end
  end

  // R8
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop && !rd_strobe && !clr_fer && !clr_ore |=>
      $stable(data_full) && $stable(frame_err) && $stable(overrun) && $stable(rx_data));

  // R10
  wake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hit && !wake_set |=> !wake_en && mp_flag);

  // R4
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_ev && !clr_ore |=> overrun && $stable(rx_data));

  // R6
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en && !rd_strobe && !clr_fer && !clr_ore |=>
      $stable(data_full) && $stable(frame_err) && $stable(overrun));

  // R7
  mode_off_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mp_mode && !wake_set && !wake_clr |=> $stable(wake_en));
endmodule

// File: rtl/mpwake_uart_rx.sv
module mpwake_uart_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rx_line,
  input  logic       rx_en,
  input  logic       mp_mode,
  input  logic       wake_set,
  input  logic       wake_clr,
  input  logic       rx_irq_en,
  input  logic       rd_strobe,
  input  logic       clr_fer,
  input  logic       clr_ore,
  input  logic       clr_mpbf,
  output logic [7:0] rx_data,
  output logic       data_full,
  output logic       frame_err,
  output logic       overrun,
  output logic       mp_flag,
  output logic       wake_armed,
  output logic       rx_irq,
  output logic       err_irq
);
  import mpwake_pkg::*;

  logic      fr_valid;
  rx_frame_t fr;
  logic      wake_active;

  mpw_bit_sampler #(.OVS(OVS)) sampler_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_line(rx_line),
    .rx_en(rx_en), .fr_valid(fr_valid), .fr(fr)
  );

  mpw_rx_status status_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mp_mode(mp_mode),
    .wake_set(wake_set), .wake_clr(wake_clr), .rd_strobe(rd_strobe),
    .clr_fer(clr_fer), .clr_ore(clr_ore), .clr_mpbf(clr_mpbf),
    .fr_valid(fr_valid), .fr(fr), .rx_data(rx_data), .data_full(data_full),
    .frame_err(frame_err), .overrun(overrun), .mp_flag(mp_flag),
    .wake_en(wake_armed), .wake_active(wake_active)
  );

  assign rx_irq  = irq_rx(rx_irq_en, data_full, wake_active);
  assign err_irq = irq_err(rx_irq_en, frame_err, overrun, wake_active);
endmodule

// File: tb/mpwake_uart_rx_tb.sv
module mpwake_uart_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0, rx_line = 1'b1, rx_en = 1'b0, mp_mode = 1'b0;
  logic wake_set = 1'b0, wake_clr = 1'b0, rx_irq_en = 1'b1, rd_strobe = 1'b0;
  logic clr_fer = 1'b0, clr_ore = 1'b0, clr_mpbf = 1'b0;
  logic [7:0] rx_data;
  logic data_full, frame_err, overrun, mp_flag, wake_armed, rx_irq, err_irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mpwake_uart_rx dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_line(rx_line),
    .rx_en(rx_en), .mp_mode(mp_mode), .wake_set(wake_set), .wake_clr(wake_clr),
    .rx_irq_en(rx_irq_en), .rd_strobe(rd_strobe), .clr_fer(clr_fer),
    .clr_ore(clr_ore), .clr_mpbf(clr_mpbf), .rx_data(rx_data),
    .data_full(data_full), .frame_err(frame_err), .overrun(overrun),
    .mp_flag(mp_flag), .wake_armed(wake_armed), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  // {data[15:8], mark, stop, mp_mode, arm, exp_taken, exp_fer, exp_wake, exp_mpflag}
  localparam logic [15:0] VEC [9] = '{
    16'hA548, 16'h3CDA, 16'h5A72, 16'h8132, 16'h42F9,
    16'h7E2C, 16'h99BD, 16'hFF68, 16'h00E9
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) baud_tick = 1'b1;
      @(negedge clk) baud_tick = 1'b0;
    end
  endtask

  task automatic line_bit(input logic b);
    @(negedge clk) rx_line = b;
    tick_n(16);
  endtask

  task automatic send(input logic [7:0] d, input logic mark, input logic stop);
    line_bit(1'b0);
    for (int i = 0; i < 8; i++) line_bit(d[i]);
    line_bit(mark);
    line_bit(stop);
    @(negedge clk) rx_line = 1'b1;
    tick_n(4);
  endtask

  task automatic clear_all();
    @(negedge clk);
    rd_strobe = 1'b1; clr_fer = 1'b1; clr_ore = 1'b1; clr_mpbf = 1'b1; wake_clr = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0; clr_fer = 1'b0; clr_ore = 1'b0; clr_mpbf = 1'b0; wake_clr = 1'b0;
  endtask

  task automatic pulse_arm();
    @(negedge clk) wake_set = 1'b1;
    @(negedge clk) wake_set = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] last;
    repeat (3) @(negedge clk);
    // reset state
    chk("R2 reset data_full", data_full, 0);
    chk("R3 reset frame_err", frame_err, 0);
    chk("R4 reset overrun", overrun, 0);
    chk("R10 reset wake", wake_armed, 0);
    chk("R11 reset irqs", {rx_irq, err_irq}, 0);
    chk("R2 reset rx_data", rx_data, 0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    last = 8'h00;

    // table walk
    foreach (VEC[k]) begin
      logic [7:0] d;
      logic mark, stp, mp, arm, e_t, e_f, e_w, e_m;
      {d, mark, stp, mp, arm, e_t, e_f, e_w, e_m} = VEC[k];
      clear_all();
      @(negedge clk) mp_mode = mp;
      if (arm) pulse_arm();
      send(d, mark, stp);
      if (e_t) last = d;
      chk($sformatf("R2/R8 vec%0d data_full", k), data_full, e_t);
      chk($sformatf("R2/R8 vec%0d rx_data", k), rx_data, last);
      chk($sformatf("R3/R8 vec%0d frame_err", k), frame_err, e_f);
      chk($sformatf("R7/R10 vec%0d wake", k), wake_armed, e_w);
      chk($sformatf("R12 vec%0d mp_flag", k), mp_flag, e_m);
      chk($sformatf("R9/R11 vec%0d rx_irq", k), rx_irq, e_t & ~(e_w & mp));
      chk($sformatf("R9/R11 vec%0d err_irq", k), err_irq, e_f & ~(e_w & mp));
    end

    // R4 overrun keeps first data, R5 read clears only data_full
    clear_all();
    @(negedge clk) mp_mode = 1'b0;
    send(8'hA1, 1'b0, 1'b1);
    send(8'hB2, 1'b0, 1'b1);
    chk("R4 overrun set", overrun, 1);
    chk("R4 data kept", rx_data, 8'hA1);
    chk("R11 err_irq on overrun", err_irq, 1);
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
    chk("R5 read clears data_full", data_full, 0);
    chk("R5 overrun survives read", overrun, 1);
    @(negedge clk) clr_ore = 1'b1;
    @(negedge clk) clr_ore = 1'b0;
    chk("R5 clr_ore clears overrun", overrun, 0);

    // R6 flags hold while disabled, R1 no reception while disabled
    clear_all();
    send(8'h33, 1'b0, 1'b0);
    chk("R3 bad stop sets frame_err", frame_err, 1);
    @(negedge clk) rx_en = 1'b0;
    send(8'h44, 1'b0, 1'b1);
    chk("R6 data_full held", data_full, 1);
    chk("R6 frame_err held", frame_err, 1);
    chk("R6 rx_data held", rx_data, 8'h33);
    clear_all();
    send(8'h55, 1'b0, 1'b1);
    chk("R1 disabled no receive", data_full, 0);
    chk("R1 disabled rx_data", rx_data, 8'h33);
    @(negedge clk) rx_en = 1'b1;

    // R1 short glitch rejected
    @(negedge clk) rx_line = 1'b0;
    tick_n(3);
    @(negedge clk) rx_line = 1'b1;
    tick_n(200);
    chk("R1 glitch ignored", data_full, 0);
    send(8'hC3, 1'b0, 1'b1);
    chk("R1 frame after glitch", rx_data, 8'hC3);

    // R9 interrupts masked while armed, R10 address wakes with overrun
    clear_all();
    @(negedge clk) mp_mode = 1'b1;
    send(8'h66, 1'b0, 1'b1);
    chk("R11 rx_irq before arm", rx_irq, 1);
    pulse_arm();
    chk("R9 rx_irq masked", rx_irq, 0);
    send(8'h77, 1'b1, 1'b1);
    chk("R10 wake cleared", wake_armed, 0);
    chk("R10 overrun after wake", overrun, 1);
    chk("R10 data kept", rx_data, 8'h66);
    chk("R10 irqs raised", {rx_irq, err_irq}, 2'b11);

    // R11 enable off masks both
    @(negedge clk) rx_irq_en = 1'b0;
    @(negedge clk);
    chk("R11 irqs masked by enable", {rx_irq, err_irq}, 2'b00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule